// File: doc/BRIEF.md
# UART Register Front End with Receive Queue

This block sits between an APB bus and the byte-level side of a serial port. Software reaches three live registers through it: a data port, a read-only status word and a read/write control word. Bytes coming in from a receiver arrive on a valid/ready byte input and wait in a parameterised queue. A read of the data port returns the oldest waiting byte and removes it. Bytes written to the data port go to a one-entry holding slot. The slot drives a valid/ready byte output toward a transmitter.

The control word gates both directions, and each direction has its own interrupt enable. An accepted event produces one clock-wide pulse on `irq`. The scaler and debug offsets decode, read as zero and drop writes. Control bits beyond the four used here are stored and read back but change nothing. Status bits come from the queue fill level and from the occupancy of the transmit slot.

Top module: `ufr_apb_uart`

## Requirements
- R1: After reset, status reads 0x0000_0006 (bits 1 and 2 set), control reads 0, `rx_ready`, `tx_valid` and `irq` are low, and `pready` is high.
- R2: Control (offset 0x08) stores all 32 written bits and reads them back unchanged. Bits other than 0..3 have no effect on any output.
- R3: Writes to status (0x04), scaler (0x0C) and debug (0x10) change nothing. Scaler, debug and any unmapped offset read as zero.
- R4: `rx_ready` equals control bit 0 (receive enable) AND queue-not-full. A byte is taken only on a cycle with both `rx_valid` and `rx_ready` high.
- R5: A read at offset 0x00 or 0x03 returns the oldest queued byte in bits 7:0, with bits 31:8 zero. Each such access removes exactly one byte, in arrival order.
- R6: A data read while the queue is empty returns zero and leaves the queue untouched.
- R7: Status bit 0 is set while the queue holds a byte. Bit 8 is set while it holds at least RX_DEPTH/2 bytes. Bit 10 is set while it is full.
- R8: A write at 0x00 or 0x03 loads pwdata[7:0] into the transmit slot only if control bit 1 (transmit enable) is set and the slot is empty; any other data write is dropped. A loaded byte stays on `tx_data` with `tx_valid` high until a cycle with `tx_ready` high.
- R9: Status bits 1 and 2 are set exactly when the transmit slot is empty. Bit 9 is set exactly when it is occupied. Bits 3 through 7 read as zero.
- R10: `irq` is high for exactly one cycle, the cycle after a byte is taken with control bit 2 set or a byte is loaded with control bit 3 set. Both in one cycle give a single pulse.
- R11: `pready` is always high, so every access completes in its access phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 5 | APB byte offset |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, tied high |
| rx_data | input | 8 | Incoming byte |
| rx_valid | input | 1 | Incoming byte present |
| rx_ready | output | 1 | Queue will take a byte |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | Outgoing byte present |
| tx_ready | input | 1 | Transmitter takes the byte |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The properties assume well-formed APB traffic: one setup cycle with `penable` low, then one access cycle, and no change to the address or write flag in between. The interrupt-cause and pop-count properties rely on this, because they match an access only by its access phase. The bench drives every input on the falling clock edge, issues one bus access at a time and raises `rx_valid` for single cycles only. Under those conditions, each access phase in the bench corresponds to exactly one register operation.

// File: rtl/ufr_pkg.sv
package ufr_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned OFS_W  = 5;

    // register offsets
    localparam logic [OFS_W-1:0] OFS_DATA   = 5'h00;
    localparam logic [OFS_W-1:0] OFS_DATA_B = 5'h03;
    localparam logic [OFS_W-1:0] OFS_STAT   = 5'h04;
    localparam logic [OFS_W-1:0] OFS_CTRL   = 5'h08;
    localparam logic [OFS_W-1:0] OFS_SCALE  = 5'h0C;
    localparam logic [OFS_W-1:0] OFS_DBG    = 5'h10;

    // control bits that act
    localparam int unsigned CB_RX_ON  = 0;
    localparam int unsigned CB_TX_ON  = 1;
    localparam int unsigned CB_RX_IRQ = 2;
    localparam int unsigned CB_TX_IRQ = 3;

    // status bits
    localparam int unsigned SB_HAVE_BYTE = 0;
    localparam int unsigned SB_SHIFT_MT  = 1;
    localparam int unsigned SB_TXQ_MT    = 2;
    localparam int unsigned SB_RXQ_HALF  = 8;
    localparam int unsigned SB_TXQ_FULL  = 9;
    localparam int unsigned SB_RXQ_FULL  = 10;

endpackage

// File: rtl/ufr_rx_fifo.sv
module ufr_rx_fifo #(
    parameter  int unsigned DEPTH = 16,
    localparam int unsigned PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [7:0]    push_byte,
    input  logic          pop,
    output logic [7:0]    head,
    output logic [CW-1:0] count
);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [PW-1:0]         wp;
        logic [PW-1:0]         rp;
        logic [CW-1:0]         cnt;
    } fifo_t;

    fifo_t fifo_d, fifo_q;

    always_comb begin
        fifo_d = fifo_q;
        if (push) begin
            fifo_d.mem[fifo_q.wp] = push_byte;
            fifo_d.wp = (fifo_q.wp == PW'(DEPTH - 1)) ? '0 : fifo_q.wp + PW'(1);
        end
        if (pop) begin
            fifo_d.rp = (fifo_q.rp == PW'(DEPTH - 1)) ? '0 : fifo_q.rp + PW'(1);
        end
        case ({push, pop})
            2'b10:   fifo_d.cnt = fifo_q.cnt + CW'(1);
            2'b01:   fifo_d.cnt = fifo_q.cnt - CW'(1);
            default: fifo_d.cnt = fifo_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fifo_q <= '0;
        else        fifo_q <= fifo_d;
    end

    assign head  = fifo_q.mem[fifo_q.rp];
    assign count = fifo_q.cnt;

endmodule

// File: rtl/ufr_tx_slot.sv
module ufr_tx_slot (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  logic       out_ready,
    output logic       out_valid,
    output logic [7:0] out_byte
);

    typedef struct packed {
        logic       full;
        logic [7:0] dat;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (slot_q.full && out_ready) slot_d.full = 1'b0;
        if (load) begin
            slot_d.full = 1'b1;
            slot_d.dat  = load_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign out_valid = slot_q.full;
    assign out_byte  = slot_q.dat;

endmodule

// File: rtl/ufr_apb_uart.sv
module ufr_apb_uart
    import ufr_pkg::*;
#(
    parameter  int unsigned RX_DEPTH = 16,
    localparam int unsigned CW       = $clog2(RX_DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        psel,
    input  logic        penable,
    input  logic        pwrite,
    input  logic [4:0]  paddr,
    input  logic [31:0] pwdata,
    output logic [31:0] prdata,
    output logic        pready,
    input  logic [7:0]  rx_data,
    input  logic        rx_valid,
    output logic        rx_ready,
    output logic [7:0]  tx_data,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic        irq
);

    typedef struct packed {
        logic [WORD_W-1:0] ctrl;
        logic              irq;
    } top_t;

    top_t top_d, top_q;

    logic              acc, rd_acc, wr_acc, hit_data;
    logic              rx_take, rx_pop, tx_load;
    logic              rx_empty, rx_full;
    logic [7:0]        rx_head;
    logic [CW-1:0]     rx_count;
    logic [WORD_W-1:0] ctrl_now;
    logic [WORD_W-1:0] stat;
    logic [WORD_W-1:0] rd_mux;

    assign ctrl_now = top_q.ctrl;
    assign acc      = psel & penable;
    assign rd_acc   = acc & ~pwrite;
    assign wr_acc   = acc & pwrite;
    assign hit_data = (paddr == OFS_DATA) || (paddr == OFS_DATA_B);

    assign rx_empty = (rx_count == '0);
    assign rx_full  = (rx_count == CW'(RX_DEPTH));
    assign rx_ready = ctrl_now[CB_RX_ON] & ~rx_full;
    assign rx_take  = rx_valid & rx_ready;
    assign rx_pop   = rd_acc & hit_data & ~rx_empty;
    assign tx_load  = wr_acc & hit_data & ctrl_now[CB_TX_ON] & ~tx_valid;

    ufr_rx_fifo #(.DEPTH(RX_DEPTH)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_take),
        .push_byte (rx_data),
        .pop       (rx_pop),
        .head      (rx_head),
        .count     (rx_count)
    );

    ufr_tx_slot u_txs (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tx_load),
        .load_byte (pwdata[7:0]),
        .out_ready (tx_ready),
        .out_valid (tx_valid),
        .out_byte  (tx_data)
    );

    always_comb begin
        stat               = '0;
        stat[SB_HAVE_BYTE] = ~rx_empty;
        stat[SB_SHIFT_MT]  = ~tx_valid;
        stat[SB_TXQ_MT]    = ~tx_valid;
        stat[SB_TXQ_FULL]  = tx_valid;
        stat[SB_RXQ_HALF]  = (rx_count >= CW'(RX_DEPTH / 2));
        stat[SB_RXQ_FULL]  = rx_full;
    end

    always_comb begin
        case (paddr)
            OFS_DATA, OFS_DATA_B: rd_mux = {24'b0, rx_empty ? 8'h00 : rx_head};
            OFS_STAT:             rd_mux = stat;
            OFS_CTRL:             rd_mux = ctrl_now;
            OFS_SCALE, OFS_DBG:   rd_mux = '0;
            default:              rd_mux = '0;
        endcase
    end

    assign prdata = (psel && !pwrite) ? rd_mux : '0;
    assign pready = 1'b1;

    always_comb begin
        top_d = top_q;
        if (wr_acc && paddr == OFS_CTRL) top_d.ctrl = pwdata;
        top_d.irq = (rx_take & ctrl_now[CB_RX_IRQ]) | (tx_load & ctrl_now[CB_TX_IRQ]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign irq = top_q.irq;

endmodule

// File: rtl/ufr_checks.sv
module ufr_checks #(
    parameter  int unsigned RX_DEPTH = 16,
    localparam int unsigned CW       = $clog2(RX_DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          psel,
    input logic          penable,
    input logic          pwrite,
    input logic [4:0]    paddr,
    input logic          pready,
    input logic          rx_valid,
    input logic          rx_ready,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic [7:0]    tx_data,
    input logic          irq,
    input logic [31:0]   ctrl_now,
    input logic [CW-1:0] rx_count
);

    logic dat_acc;
    assign dat_acc = psel && penable && (paddr == 5'h00 || paddr == 5'h03);

    AST_ALWAYS_READY: assert property (@(posedge clk) disable iff (!rst_n) pready); // R11

    AST_RX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_now[0] |-> !rx_ready); // R4

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == CW'(RX_DEPTH)) |-> !rx_ready); // R4

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= CW'(RX_DEPTH)); // R7

    AST_POP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_acc && !pwrite && rx_count != '0 && !(rx_valid && rx_ready))
        |=> rx_count == $past(rx_count) - CW'(1)); // R5

    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_acc && !pwrite && rx_count == '0 && !(rx_valid && rx_ready))
        |=> rx_count == '0); // R6

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R8

    AST_TX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_valid && !ctrl_now[1]) |=> !tx_valid); // R8

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past((rx_valid && rx_ready && ctrl_now[2]) ||
                      (dat_acc && pwrite && ctrl_now[3]))); // R10

endmodule

bind ufr_apb_uart ufr_checks #(.RX_DEPTH(RX_DEPTH)) u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .pready   (pready),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .irq      (irq),
    .ctrl_now (ctrl_now),
    .rx_count (rx_count)
);

// File: tb/sim_ufr_apb_uart.sv
`timescale 1ns/1ps
module sim_ufr_apb_uart;

    localparam int unsigned DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [4:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic        irq;

    int total = 0;
    int bad = 0;
    int irq_seen = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ufr_apb_uart #(.RX_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .irq(irq)
    );

    always @(negedge clk) if (rst_n && irq === 1'b1) irq_seen++;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic feed(input logic [7:0] b, output bit took);
        @(negedge clk);
        rx_data = b; rx_valid = 1'b1;
        #1 took = rx_ready;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    function automatic logic [31:0] exp_stat(input int n, input bit slot);
        logic [31:0] s = '0;
        s[0]  = (n > 0);
        s[1]  = !slot;
        s[2]  = !slot;
        s[8]  = (n >= DEPTH / 2);
        s[9]  = slot;
        s[10] = (n == DEPTH);
        return s;
    endfunction

    initial begin
        #2_000_000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        bit took;
        int base;

        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        bus_rd(5'h04, v); chk(v == 32'h6, "R1 status", v, 32'h6);
        bus_rd(5'h08, v); chk(v == 32'h0, "R1 control", v, 32'h0);
        chk(rx_ready == 1'b0 && tx_valid == 1'b0 && irq == 1'b0, "R1 outputs",
            {29'b0, rx_ready, tx_valid, irq}, 32'h0);
        chk(pready == 1'b1, "R11 pready", {31'b0, pready}, 32'h1);

        // R2 control read-back: walking ones plus patterns
        for (int i = 0; i < 32; i++) begin
            bus_wr(5'h08, 32'h1 << i);
            bus_rd(5'h08, v);
            chk(v == (32'h1 << i), "R2 walk", v, 32'h1 << i);
        end
        bus_wr(5'h08, 32'hA5A5_5A5A); bus_rd(5'h08, v);
        chk(v == 32'hA5A5_5A5A, "R2 pattern", v, 32'hA5A5_5A5A);
        // R2 stored-only bits have no effect
        bus_wr(5'h08, 32'hFFFF_FFF0);
        bus_rd(5'h04, v); chk(v == 32'h6, "R2 inert status", v, 32'h6);
        chk(rx_ready == 1'b0, "R2 inert rx_ready", {31'b0, rx_ready}, 32'h0);
        bus_wr(5'h00, 32'h5A);
        chk(tx_valid == 1'b0, "R2 inert tx", {31'b0, tx_valid}, 32'h0);
        bus_wr(5'h08, 32'h0);

        // R3 inert offsets
        bus_wr(5'h04, 32'hFFFF_FFFF); bus_rd(5'h04, v);
        chk(v == 32'h6, "R3 status ro", v, 32'h6);
        bus_wr(5'h0C, 32'h1234); bus_rd(5'h0C, v);
        chk(v == 32'h0, "R3 scaler", v, 32'h0);
        bus_wr(5'h10, 32'hFFFF); bus_rd(5'h10, v);
        chk(v == 32'h0, "R3 debug", v, 32'h0);
        bus_rd(5'h14, v); chk(v == 32'h0, "R3 unmapped", v, 32'h0);
        bus_rd(5'h08, v); chk(v == 32'h0, "R3 control untouched", v, 32'h0);

        // R4 receive disabled
        feed(8'h11, took);
        chk(!took, "R4 disabled", {31'b0, took}, 32'h0);
        bus_rd(5'h04, v); chk(v == exp_stat(0, 0), "R4 nothing queued", v, exp_stat(0, 0));

        // R4 R7 fill sweep
        bus_wr(5'h08, 32'h1);
        base = irq_seen;
        for (int n = 1; n <= DEPTH; n++) begin
            feed(8'((n * 7 + 3) & 8'hFF), took);
            chk(took, "R4 accept", {31'b0, took}, 32'h1);
            bus_rd(5'h04, v);
            chk(v == exp_stat(n, 0), "R7 fill status", v, exp_stat(n, 0));
        end
        feed(8'hEE, took);
        chk(!took, "R4 full blocks", {31'b0, took}, 32'h0);
        idle(1);
        chk(irq_seen == base, "R10 no rx irq when disabled", irq_seen, base);

        // R5 R7 drain alternating lanes
        for (int n = 1; n <= DEPTH; n++) begin
            bus_rd((n % 2) ? 5'h00 : 5'h03, v);
            chk(v == ((n * 7 + 3) & 32'hFF), "R5 order", v, (n * 7 + 3) & 32'hFF);
            bus_rd(5'h04, v);
            chk(v == exp_stat(DEPTH - n, 0), "R7 drain status", v, exp_stat(DEPTH - n, 0));
        end

        // R6 empty read
        bus_rd(5'h00, v); chk(v == 32'h0, "R6 empty data", v, 32'h0);
        bus_rd(5'h04, v); chk(v == exp_stat(0, 0), "R6 empty status", v, exp_stat(0, 0));
        feed(8'hC7, took);
        bus_rd(5'h03, v); chk(v == 32'hC7, "R6 queue intact", v, 32'hC7);

        // R10 receive interrupts
        bus_wr(5'h08, 32'h5);
        base = irq_seen;
        for (int i = 0; i < 3; i++) begin
            feed(8'(i + 1), took);
            idle(2);
        end
        chk(irq_seen == base + 3, "R10 rx pulses", irq_seen, base + 3);
        for (int i = 0; i < 3; i++) bus_rd(5'h00, v);

        // R8 transmit disabled
        bus_wr(5'h08, 32'h0);
        bus_wr(5'h00, 32'h155);
        chk(tx_valid == 1'b0, "R8 tx disabled", {31'b0, tx_valid}, 32'h0);

        // R8 R9 R10 transmit hold
        bus_wr(5'h08, 32'hA);
        base = irq_seen;
        bus_wr(5'h00, 32'h1C3);
        chk(tx_valid == 1'b1 && tx_data == 8'hC3, "R8 load", {23'b0, tx_valid, tx_data}, 32'h1C3);
        idle(1);
        chk(irq_seen == base + 1, "R10 tx pulse", irq_seen, base + 1);
        bus_rd(5'h04, v); chk(v == exp_stat(0, 1), "R9 busy status", v, exp_stat(0, 1));
        bus_wr(5'h03, 32'h77);
        idle(1);
        chk(tx_data == 8'hC3 && tx_valid, "R8 busy drop", {24'b0, tx_data}, 32'hC3);
        chk(irq_seen == base + 1, "R10 no pulse on drop", irq_seen, base + 1);
        tx_ready = 1'b1;
        @(negedge clk);
        chk(tx_valid == 1'b0, "R8 handoff", {31'b0, tx_valid}, 32'h0);
        bus_rd(5'h04, v); chk(v == exp_stat(0, 0), "R9 free status", v, exp_stat(0, 0));

        // R8 byte lane with ready already high
        bus_wr(5'h03, 32'hFF4E);
        chk(tx_valid && tx_data == 8'h4E, "R8 lane3", {23'b0, tx_valid, tx_data}, 32'h14E);
        @(negedge clk);
        chk(tx_valid == 1'b0, "R8 one cycle", {31'b0, tx_valid}, 32'h0);

        // R10 coincident events give one pulse
        bus_wr(5'h08, 32'hF);
        idle(2);
        base = irq_seen;
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = 5'h00; pwdata = 32'h99; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1; rx_valid = 1'b1; rx_data = 8'h3C;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0; rx_valid = 1'b0;
        idle(3);
        chk(irq_seen == base + 1, "R10 merged pulse", irq_seen, base + 1);
        bus_rd(5'h00, v); chk(v == 32'h3C, "R5 coincident byte", v, 32'h3C);
        chk(pready == 1'b1, "R11 pready end", {31'b0, pready}, 32'h1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule